// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a video output. Two counters step through every pixel of a line and every line of a frame. Comparators on those counters drive a display-enable flag, raw horizontal and vertical sync pulses, and a one-cycle strobe that tells the pixel fetch logic to start loading the next line. The pixel address sent to the fetch logic is the counter position plus a programmable pan origin.

Software programs the mode through a simple write port. Each threshold is written as the last counted position, which is the count minus one. The horizontal and vertical totals, active sizes, and sync edges follow this rule. The prefetch column is stored as `htotal - prefetch - 1`. Timing and pan values are first written to a pending set. They are copied to the working set only at a frame boundary, so each frame is generated with one consistent mode. While the generator is stopped, the copy happens on every cycle.

After reset the working set holds a 1280x1024 mode. Its horizontal porches are 48 front and 248 back with a 112-pixel sync. Its vertical porches are 1 line front and 38 lines back with a 3-line sync. The prefetch count is 355 pixels.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the generator is stopped. disp_en, hsync, vsync and line_prefetch are low and pix_x/pix_y are 0. The timing set holds the 1280x1024 mode: htotal-1 = 1687, active-1 = 1279, hsync start 1327, hsync end 1439, vtotal-1 = 1065, active-1 = 1023, vsync start 1024, vsync end 1027, prefetch threshold 1332.
- R2: While running, the column counter steps by one each cycle from 0 up to the programmed total. It then wraps to 0 and advances the line counter. After the last column of the last line the position returns to (0,0).
- R3: disp_en is high exactly when the generator runs, refresh is on, column <= active width value and line <= active height value.
- R4: hsync is high exactly when the generator runs and hsync start < column <= hsync end.
- R5: vsync is high exactly when the generator runs and vsync start < line <= vsync end.
- R6: line_prefetch pulses for one cycle when the column equals the threshold. This happens only when refresh is on and only on lines whose following line is active. The line after the last one is line 0.
- R7: A prefetch threshold above the horizontal total behaves as the total, so the strobe fires on the last column.
- R8: Register 0 holds the control bits: bit 0 runs the generator and bit 1 enables refresh. Control writes act on the next cycle. Clearing bit 0 forces every output low, sets pix to the pan origin and holds the counters at 0. Setting it again restarts at (0,0) on the next cycle. With bit 1 clear, disp_en and line_prefetch stay low but the syncs keep running.
- R9: pix_x = column + pan x and pix_y = line + pan y, both modulo 2^16.
- R10: Register 10 holds the pan origin, with x in bits [31:16] and y in bits [15:0]. A write whose x is not a multiple of 8 is ignored in full.
- R11: Writes to registers 1 to 10 made while running take effect at the first pixel of the next frame. While stopped they take effect on the next cycle.
- R12: Timing registers are at these addresses: 1 htotal, 2 hactive, 3 hsync start, 4 hsync end, 5 vtotal, 6 vactive, 7 vsync start, 8 vsync end, 9 prefetch threshold. Writes to addresses 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register index |
| wr_data | input | DW | Register write value |
| pix_x | output | DW/2 | Column address including pan x |
| pix_y | output | DW/2 | Line address including pan y |
| disp_en | output | 1 | Active-display flag |
| hsync | output | 1 | Raw horizontal sync |
| vsync | output | 1 | Raw vertical sync |
| line_prefetch | output | 1 | One-cycle fetch strobe for the next line |

## Verification
The hardest case to reach from the ports is a write that lands partway through a frame. The bench must show that the old value still governs the rest of that frame and that the new value starts exactly at the next (0,0). The bench aligns itself to a frame by waiting for vsync to fall, which happens at the start of the last line. It then counts one line of cycles to reach the frame origin. From there it issues writes at known positions and samples the outputs both before and after the boundary. The same alignment is used to place rejected and accepted pan writes, and to place a prefetch threshold beyond the line end.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Register indices on the write port
    typedef enum logic [3:0] {
        DTG_CTRL  = 4'd0,
        DTG_HTOT  = 4'd1,
        DTG_HACT  = 4'd2,
        DTG_HSS   = 4'd3,
        DTG_HSE   = 4'd4,
        DTG_VTOT  = 4'd5,
        DTG_VACT  = 4'd6,
        DTG_VSS   = 4'd7,
        DTG_VSE   = 4'd8,
        DTG_PFT   = 4'd9,
        DTG_PAN   = 4'd10
    } dtg_reg_e;

    // Positions inside the timing array (register index minus one)
    localparam int TI_HTOT = 0;
    localparam int TI_HACT = 1;
    localparam int TI_HSS  = 2;
    localparam int TI_HSE  = 3;
    localparam int TI_VTOT = 4;
    localparam int TI_VACT = 5;
    localparam int TI_VSS  = 6;
    localparam int TI_VSE  = 7;
    localparam int TI_PFT  = 8;
    localparam int DTG_NUM_TIMING = 9;

    // Pan x must be aligned to this many low zero bits
    localparam int PAN_X_ALIGN_BITS = 3;

endpackage

// File: rtl/dtg_regfile.sv
module dtg_regfile
    import dtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 4,
    parameter int DW = 32,
    parameter logic [DTG_NUM_TIMING*CW-1:0] RST_TIMING = '0
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [AW-1:0]                          wr_addr,
    input  logic [DW-1:0]                          wr_data,
    input  logic                                   commit,
    output logic                                   run,
    output logic                                   refr,
    output logic [DTG_NUM_TIMING-1:0][CW-1:0]      timing,
    output logic [DW/2-1:0]                        pan_x,
    output logic [DW/2-1:0]                        pan_y
);

    localparam int NT = DTG_NUM_TIMING;
    localparam int PW = DW / 2;

    typedef struct packed {
        logic                   run;
        logic                   refr;
        logic [NT-1:0][CW-1:0]  pend;
        logic [NT-1:0][CW-1:0]  act;
        logic [PW-1:0]          pend_px;
        logic [PW-1:0]          pend_py;
        logic [PW-1:0]          act_px;
        logic [PW-1:0]          act_py;
    } rf_t;

    rf_t s_d, s_q;
    logic pan_ok;

    assign pan_ok = (wr_data[PW +: PAN_X_ALIGN_BITS] == '0);

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (wr_addr == AW'(DTG_CTRL)) begin
                s_d.run  = wr_data[0];
                s_d.refr = wr_data[1];
            end
            for (int i = 0; i < NT; i++) begin
                if (wr_addr == AW'(i + 1)) begin
                    s_d.pend[i] = wr_data[CW-1:0];
                end
            end
            if (wr_addr == AW'(DTG_PAN) && pan_ok) begin
                s_d.pend_px = wr_data[DW-1:PW];
                s_d.pend_py = wr_data[PW-1:0];
            end
        end
        // working set only moves at a frame boundary or while stopped
        if (commit) begin
            s_d.act    = s_q.pend;
            s_d.act_px = s_q.pend_px;
            s_d.act_py = s_q.pend_py;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.run     <= 1'b0;
            s_q.refr    <= 1'b0;
            s_q.pend    <= RST_TIMING;
            s_q.act     <= RST_TIMING;
            s_q.pend_px <= '0;
            s_q.pend_py <= '0;
            s_q.act_px  <= '0;
            s_q.act_py  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run    = s_q.run;
    assign refr   = s_q.refr;
    assign timing = s_q.act;
    assign pan_x  = s_q.act_px;
    assign pan_y  = s_q.act_py;

endmodule

// File: rtl/dtg_counter.sv
module dtg_counter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] h_tot,
    input  logic [CW-1:0] v_tot,
    output logic [CW-1:0] h_cnt,
    output logic [CW-1:0] v_cnt,
    output logic          frame_end
);

    typedef struct packed {
        logic [CW-1:0] h;
        logic [CW-1:0] v;
    } pos_t;

    pos_t p_d, p_q;
    logic h_last, v_last;

    assign h_last = (p_q.h == h_tot);
    assign v_last = (p_q.v == v_tot);

    always_comb begin
        p_d = p_q;
        if (!run) begin
            p_d.h = '0;
            p_d.v = '0;
        end else if (h_last) begin
            p_d.h = '0;
            p_d.v = v_last ? '0 : p_q.v + CW'(1);
        end else begin
            p_d.h = p_q.h + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign h_cnt     = p_q.h;
    assign v_cnt     = p_q.v;
    assign frame_end = run && h_last && v_last;

endmodule

// File: rtl/dtg_decode.sv
module dtg_decode #(
    parameter int CW = 12,
    parameter int PW = 16
) (
    input  logic          run,
    input  logic          refr,
    input  logic [CW-1:0] h_cnt,
    input  logic [CW-1:0] v_cnt,
    input  logic [CW-1:0] h_tot,
    input  logic [CW-1:0] h_act,
    input  logic [CW-1:0] hs_start,
    input  logic [CW-1:0] hs_end,
    input  logic [CW-1:0] v_tot,
    input  logic [CW-1:0] v_act,
    input  logic [CW-1:0] vs_start,
    input  logic [CW-1:0] vs_end,
    input  logic [CW-1:0] pf_thr,
    input  logic [PW-1:0] pan_x,
    input  logic [PW-1:0] pan_y,
    output logic          disp_en,
    output logic          hsync,
    output logic          vsync,
    output logic          line_prefetch,
    output logic [PW-1:0] pix_x,
    output logic [PW-1:0] pix_y
);

    logic [CW-1:0] thr_eff;
    logic [CW-1:0] v_next;
    logic          in_h, in_v, next_vis, show;

    always_comb begin
        // a threshold past the line end is pulled back onto the last column
        thr_eff  = (pf_thr > h_tot) ? h_tot : pf_thr;
        v_next   = (v_cnt == v_tot) ? '0 : v_cnt + CW'(1);
        next_vis = (v_next <= v_act);
        in_h     = (h_cnt <= h_act);
        in_v     = (v_cnt <= v_act);
        show     = run && refr;

        disp_en       = show && in_h && in_v;
        hsync         = run && (h_cnt > hs_start) && (h_cnt <= hs_end);
        vsync         = run && (v_cnt > vs_start) && (v_cnt <= vs_end);
        line_prefetch = show && next_vis && (h_cnt == thr_eff);

        pix_x = run ? PW'(h_cnt) + pan_x : pan_x;
        pix_y = run ? PW'(v_cnt) + pan_y : pan_y;
    end

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 4,
    parameter int DW = 32,
    parameter int H_ACTIVE = 1280,
    parameter int H_FRONT  = 48,
    parameter int H_SYNC   = 112,
    parameter int H_BACK   = 248,
    parameter int V_ACTIVE = 1024,
    parameter int V_FRONT  = 1,
    parameter int V_SYNC   = 3,
    parameter int V_BACK   = 38,
    parameter int PREFETCH = 355
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic [DW/2-1:0] pix_x,
    output logic [DW/2-1:0] pix_y,
    output logic            disp_en,
    output logic            hsync,
    output logic            vsync,
    output logic            line_prefetch
);

    localparam int NT      = DTG_NUM_TIMING;
    localparam int PW      = DW / 2;
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
    localparam int PF_CLMP = (PREFETCH >= H_TOTAL) ? H_TOTAL - 1 : PREFETCH;

    localparam logic [NT*CW-1:0] RST_TIMING = {
        CW'(H_TOTAL - PF_CLMP - 1),
        CW'(V_ACTIVE + V_FRONT + V_SYNC - 1),
        CW'(V_ACTIVE + V_FRONT - 1),
        CW'(V_ACTIVE - 1),
        CW'(V_TOTAL - 1),
        CW'(H_ACTIVE + H_FRONT + H_SYNC - 1),
        CW'(H_ACTIVE + H_FRONT - 1),
        CW'(H_ACTIVE - 1),
        CW'(H_TOTAL - 1)
    };

    logic                   run, refr, commit, frame_end;
    logic [NT-1:0][CW-1:0]  timing;
    logic [PW-1:0]          pan_x, pan_y;
    logic [CW-1:0]          h_cnt, v_cnt, h_tot, v_tot;

    assign h_tot  = timing[TI_HTOT];
    assign v_tot  = timing[TI_VTOT];
    assign commit = !run || frame_end;

    dtg_regfile #(
        .CW(CW), .AW(AW), .DW(DW), .RST_TIMING(RST_TIMING)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (commit),
        .run     (run),
        .refr    (refr),
        .timing  (timing),
        .pan_x   (pan_x),
        .pan_y   (pan_y)
    );

    dtg_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .h_tot     (h_tot),
        .v_tot     (v_tot),
        .h_cnt     (h_cnt),
        .v_cnt     (v_cnt),
        .frame_end (frame_end)
    );

    dtg_decode #(.CW(CW), .PW(PW)) u_dec (
        .run           (run),
        .refr          (refr),
        .h_cnt         (h_cnt),
        .v_cnt         (v_cnt),
        .h_tot         (h_tot),
        .h_act         (timing[TI_HACT]),
        .hs_start      (timing[TI_HSS]),
        .hs_end        (timing[TI_HSE]),
        .v_tot         (v_tot),
        .v_act         (timing[TI_VACT]),
        .vs_start      (timing[TI_VSS]),
        .vs_end        (timing[TI_VSE]),
        .pf_thr        (timing[TI_PFT]),
        .pan_x         (pan_x),
        .pan_y         (pan_y),
        .disp_en       (disp_en),
        .hsync         (hsync),
        .vsync         (vsync),
        .line_prefetch (line_prefetch),
        .pix_x         (pix_x),
        .pix_y         (pix_y)
    );

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
    parameter int CW = 12,
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          refr,
    input logic          frame_end,
    input logic [CW-1:0] h_cnt,
    input logic [CW-1:0] v_cnt,
    input logic [CW-1:0] h_tot,
    input logic [PW-1:0] pan_x,
    input logic          disp_en,
    input logic          hsync,
    input logic          vsync,
    input logic          line_prefetch
);

    // R8
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (h_cnt == '0 && v_cnt == '0));

    // R8
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!disp_en && !hsync && !vsync && !line_prefetch));

    // R2
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && h_cnt != h_tot) |=> (h_cnt == $past(h_cnt) + CW'(1)));

    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (h_cnt == '0 && v_cnt == '0));

    // R11
    mid_frame_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_end) |=> $stable(h_tot));

    // R10
    pan_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pan_x[2:0] == 3'b000);

    // R3
    refresh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en || line_prefetch) |-> refr);

endmodule

bind disp_timing_gen dtg_checker #(.CW(CW), .PW(PW)) i_dtg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .refr          (refr),
    .frame_end     (frame_end),
    .h_cnt         (h_cnt),
    .v_cnt         (v_cnt),
    .h_tot         (h_tot),
    .pan_x         (pan_x),
    .disp_en       (disp_en),
    .hsync         (hsync),
    .vsync         (vsync),
    .line_prefetch (line_prefetch)
);

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int PW = DW / 2;
    localparam int HT = 16;
    localparam int VT = 8;
    localparam int PX0 = 8;
    localparam int PY0 = 2;
    localparam int NV = 16;

    typedef struct packed {
        logic [7:0] h;
        logic [7:0] v;
        logic       de;
        logic       hs;
        logic       vs;
        logic       pf;
    } vec_t;

    // small mode: active 8, fp 2, sync 3, bp 3 ; lines active 4, fp 1, sync 2, bp 1 ; threshold 13
    localparam vec_t VECS [NV] = '{
        '{8'd0,  8'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'd7,  8'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'd8,  8'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'd9,  8'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'd10, 8'd0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'd12, 8'd0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'd13, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{8'd15, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'd0,  8'd3, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'd13, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'd0,  8'd4, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'd3,  8'd5, 1'b0, 1'b0, 1'b1, 1'b0},
        '{8'd15, 8'd6, 1'b0, 1'b0, 1'b1, 1'b0},
        '{8'd0,  8'd7, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'd13, 8'd7, 1'b0, 1'b0, 1'b0, 1'b1},
        '{8'd0,  8'd8, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    logic          clk, rst_n, wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [PW-1:0] pix_x, pix_y;
    logic          disp_en, hsync, vsync, line_prefetch;

    int nchk = 0;
    int nbad = 0;
    int cur  = 0;
    bit finished = 0;

    disp_timing_gen i_disp_timing_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .pix_x         (pix_x),
        .pix_y         (pix_y),
        .disp_en       (disp_en),
        .hsync         (hsync),
        .vsync         (vsync),
        .line_prefetch (line_prefetch)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s at pos %0d: actual=%0d expected=%0d", req, what, cur, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input int a, input logic [DW-1:0] d);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        cur++;
    endtask

    task automatic go(input int n);
        while (cur < n) begin
            @(negedge clk);
            cur++;
        end
    endtask

    // aligns to the negedge showing position (0,0) of a frame in the small mode
    task automatic sync_frame();
        do @(negedge clk); while (!vsync);
        do @(negedge clk); while (vsync);
        repeat (HT) @(negedge clk);
        cur = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "disp_en", int'(disp_en), 0);
        chk("R1", "hsync", int'(hsync), 0);
        chk("R1", "vsync", int'(vsync), 0);
        chk("R1", "prefetch", int'(line_prefetch), 0);
        chk("R1", "pix_x", int'(pix_x), 0);
        chk("R1", "pix_y", int'(pix_y), 0);

        // R1 reference mode held after reset, R8 run+refresh
        wr(0, 32'h3);
        cur = 0;
        go(1279); chk("R1", "ref de last col", int'(disp_en), 1);
        go(1280); chk("R1", "ref de past active", int'(disp_en), 0);
        go(1327); chk("R1", "ref hsync before", int'(hsync), 0);
        go(1328); chk("R1", "ref hsync first", int'(hsync), 1);
        go(1332); chk("R1", "ref prefetch", int'(line_prefetch), 1);
        go(1439); chk("R1", "ref hsync last", int'(hsync), 1);
        go(1440); chk("R1", "ref hsync after", int'(hsync), 0);

        // R8 stop: outputs quiet, pix at pan origin
        wr(0, 32'h0);
        chk("R8", "stopped de", int'(disp_en), 0);
        chk("R8", "stopped hsync", int'(hsync), 0);
        chk("R8", "stopped pix_x", int'(pix_x), 0);
        go(cur + 3);
        chk("R8", "held pix_x", int'(pix_x), 0);
        chk("R8", "held vsync", int'(vsync), 0);

        // R12 program the small mode while stopped
        wr(1, 15); wr(2, 7); wr(3, 9); wr(4, 12);
        wr(5, 7);  wr(6, 3); wr(7, 4); wr(8, 6);
        wr(9, 13); wr(10, (32'(PX0) << 16) | 32'(PY0));
        wr(0, 32'h3);
        cur = 0;

        // table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            int idx;
            idx = int'(VECS[i].v) * HT + int'(VECS[i].h);
            go(idx);
            chk("R3", "de", int'(disp_en), int'(VECS[i].de));
            chk("R4", "hsync", int'(hsync), int'(VECS[i].hs));
            chk("R5", "vsync", int'(vsync), int'(VECS[i].vs));
            chk("R6", "prefetch", int'(line_prefetch), int'(VECS[i].pf));
            chk("R9", "pix_x", int'(pix_x), (int'(VECS[i].h) % HT) + PX0);
            chk("R2", "pix_y", int'(pix_y), (int'(VECS[i].v) % VT) + PY0);
        end

        // R11 mid-frame write to active width
        sync_frame();
        go(HT);
        wr(2, 3);
        go(HT + 5); chk("R11", "old width in frame", int'(disp_en), 1);
        sync_frame();
        go(3); chk("R11", "new width col3", int'(disp_en), 1);
        go(4); chk("R11", "new width col4", int'(disp_en), 0);
        wr(2, 7);

        // R12 unused addresses change nothing
        wr(11, 32'h0); wr(15, 32'h0);
        sync_frame();
        go(7);  chk("R12", "de col7", int'(disp_en), 1);
        go(10); chk("R12", "hsync col10", int'(hsync), 1);

        // R10 misaligned pan rejected
        sync_frame();
        go(HT);
        wr(10, (32'd12 << 16) | 32'd5);
        sync_frame();
        chk("R10", "rejected pan x", int'(pix_x), PX0);
        chk("R10", "rejected pan y", int'(pix_y), PY0);
        wr(10, (32'd16 << 16) | 32'd5);
        go(2); chk("R11", "pan old in frame", int'(pix_x), 2 + PX0);
        sync_frame();
        chk("R10", "accepted pan x", int'(pix_x), 16);
        chk("R10", "accepted pan y", int'(pix_y), 5);
        go(3); chk("R9", "pix_x with new pan", int'(pix_x), 19);

        // R8 refresh off: no de/prefetch, syncs run
        sync_frame();
        wr(0, 32'h1);
        chk("R8", "refresh off de", int'(disp_en), 0);
        go(10); chk("R8", "refresh off hsync", int'(hsync), 1);
        go(13); chk("R8", "refresh off prefetch", int'(line_prefetch), 0);
        wr(0, 32'h3);

        // R7 threshold beyond line end
        wr(9, 200);
        sync_frame();
        go(13); chk("R7", "no strobe col13", int'(line_prefetch), 0);
        go(14); chk("R7", "no strobe col14", int'(line_prefetch), 0);
        go(15); chk("R7", "strobe last col", int'(line_prefetch), 1);

        // R8 stop then restart at origin
        wr(0, 32'h0);
        chk("R8", "stop pix_x", int'(pix_x), 16);
        chk("R8", "stop vsync", int'(vsync), 0);
        wr(0, 32'h3);
        chk("R8", "restart pix_x", int'(pix_x), 16);
        chk("R8", "restart pix_y", int'(pix_y), 5);
        chk("R8", "restart de", int'(disp_en), 1);
        @(negedge clk);
        chk("R8", "restart step", int'(pix_x), 17);

        finish_run();
    end

endmodule